// File: doc/BRIEF.md
# Register Stack Expression Evaluator

This block is a zero-address arithmetic engine built on a stack of 64 sixteen-bit registers. Commands arrive one per cycle on a valid/opcode/data input. A push stores the data word on the stack. A pop returns the top entry on a registered result port. An arithmetic or logic operator removes the two top entries, combines them, and stores the result in their place. A caller that feeds it a postfix (reverse Polish) token stream therefore gets the value of the expression as the single remaining entry.

The stack pointer is six bits wide and counts entries modulo 64. A push advances the pointer first and then writes at the new position. A pop reads at the current position and then moves the pointer back. Two registered flags mark the full and empty conditions, because a pointer value of zero means both "no entries" and "64 entries". Any command that cannot be carried out leaves the stack untouched and raises a sticky error flag.

Top module: `rpn_stack_engine`

## Requirements
- R1: After reset the stack is empty: `empty`=1, `full`=0, `err`=0, `rsp_valid`=0 and `top_data`=0.
- R2: A push (opcode 3'b000) with fewer than 64 entries advances the pointer, stores `cmd_data` as the new top, and clears `empty`. `top_data` shows the new value in the cycle after the command.
- R3: A pop (opcode 3'b001) on a non-empty stack pulses `rsp_valid` for one cycle, one cycle after the command, with `rsp_data` equal to the top entry. Entries come back in last-in, first-out order. `empty` is set when the pointer returns to zero.
- R4: The operators ADD (3'b010), SUB (3'b011), MUL (3'b100), AND (3'b101) and OR (3'b110) replace the two top entries with one result. The entry pushed earlier is the left operand, so it is the minuend of SUB. Results wrap to 16 bits, and MUL keeps the low 16 bits of the product.
- R5: The token stream 3 4 MUL 5 6 MUL ADD shows the tops 3, 4, 12, 5, 6, 30, 42 and leaves 42 as the only entry.
- R6: `full` stays 0 after 63 pushes and is set by the 64th push.
- R7: A push while `full` is rejected: the stack contents, the pointer and the flags stay unchanged, and `err` is set.
- R8: A pop while `empty` is rejected: there is no `rsp_valid` pulse, the flags stay unchanged, and `err` is set.
- R9: An operator with fewer than two entries is rejected: the stack is unchanged and `err` is set.
- R10: Opcode 3'b111 is undefined. It is rejected with no state change, and `err` is set.
- R11: `err` stays set through later accepted commands and is cleared only by reset.
- R12: An operator applied to a full stack uses the two top entries correctly across the pointer wrap and clears `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 16 | Operand for a push |
| rsp_valid | output | 1 | One-cycle pulse: popped value is on `rsp_data` |
| rsp_data | output | 16 | Last popped value |
| top_data | output | 16 | Current top entry, zero when the stack is empty |
| full | output | 1 | 64 entries held |
| empty | output | 1 | No entries held |
| err | output | 1 | Sticky: a command was rejected |

## Verification
An operator reads two entries, writes one and moves the pointer down, all in a single cycle. This includes the case where the stack is full: the pointer sits at zero, and the second operand lives at position 63 across the wrap. The bench fills the stack to exactly 64 entries and then issues an operator at once. It expects the sum of the two last-pushed words and a cleared full flag, and it pops the whole remainder to confirm that no lower entry was disturbed. A rejection is also provoked in the same cycle that a flag would otherwise change (a push on a full stack, a pop on an empty one). The bench judges these cases by stable flags, by the absence of a result pulse, and by the sticky error flag.

// File: rtl/rpn_pkg.sv
`timescale 1ns/1ps
package rpn_pkg;
  typedef enum logic [2:0] {
    CMD_PUSH = 3'd0,
    CMD_POP  = 3'd1,
    CMD_ADD  = 3'd2,
    CMD_SUB  = 3'd3,
    CMD_MUL  = 3'd4,
    CMD_AND  = 3'd5,
    CMD_OR   = 3'd6,
    CMD_RSVD = 3'd7
  } cmd_e;

  function automatic logic is_binary(cmd_e c);
    return (c == CMD_ADD) || (c == CMD_SUB) || (c == CMD_MUL) ||
           (c == CMD_AND) || (c == CMD_OR);
  endfunction
endpackage

// File: rtl/rpn_stack_mem.sv
`timescale 1ns/1ps
// Register array: one write port, two combinational read ports (top, next).
module rpn_stack_mem #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_top_addr,
  input  logic [PTR_W-1:0]  rd_nxt_addr,
  output logic [DATA_W-1:0] rd_top_data,
  output logic [DATA_W-1:0] rd_nxt_data
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] slot_q [DEPTH];

  // Storage carries no reset; the flags decide which slots are meaningful.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot_q[wr_addr] <= wr_data;
    end
  end

  assign rd_top_data = slot_q[rd_top_addr];
  assign rd_nxt_data = slot_q[rd_nxt_addr];
endmodule

// File: rtl/rpn_alu.sv
`timescale 1ns/1ps
// Combines the earlier-pushed entry (lhs) with the top entry (rhs).
module rpn_alu
  import rpn_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  cmd_e              op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] res
);
  logic [2*DATA_W-1:0] prod;

  always_comb begin
    prod = lhs * rhs;
    unique case (op)
      CMD_ADD: res = lhs + rhs;
      CMD_SUB: res = lhs - rhs;
      CMD_MUL: res = prod[DATA_W-1:0];
      CMD_AND: res = lhs & rhs;
      CMD_OR:  res = lhs | rhs;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rpn_ptr_ctrl.sv
`timescale 1ns/1ps
// Pointer, flags and command acceptance.
module rpn_ptr_ctrl
  import rpn_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  cmd_e             op,
  output logic [PTR_W-1:0] sp,
  output logic             full,
  output logic             empty,
  output logic             err,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic             pop_fire,
  output logic             bin_fire
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] sp_q, sp_d, sp_inc, sp_dec;
  logic             full_q, full_d, empty_q, empty_d, err_q, err_d;
  logic             two_plus, ok, fire, reject;

  always_comb begin
    sp_inc   = sp_q + ONE;
    sp_dec   = sp_q - ONE;
    two_plus = !empty_q && (full_q || (sp_q != ONE));
    unique case (op)
      CMD_PUSH: ok = !full_q;
      CMD_POP:  ok = !empty_q;
      CMD_RSVD: ok = 1'b0;
      default:  ok = two_plus;
    endcase
    fire    = cmd_valid && ok;
    reject  = cmd_valid && !ok;
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    err_d   = err_q | reject;
    wr_en   = 1'b0;
    wr_addr = sp_inc;
    if (fire) begin
      unique case (op)
        CMD_PUSH: begin
          sp_d    = sp_inc;
          empty_d = 1'b0;
          full_d  = (sp_inc == '0);
          wr_en   = 1'b1;
          wr_addr = sp_inc;
        end
        CMD_POP: begin
          sp_d    = sp_dec;
          full_d  = 1'b0;
          empty_d = (sp_dec == '0);
        end
        default: begin
          sp_d    = sp_dec;
          full_d  = 1'b0;
          wr_en   = 1'b1;
          wr_addr = sp_dec;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (fire) begin
      sp_q    <= sp_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (reject) begin
      err_q <= err_d;
    end
  end

  assign sp       = sp_q;
  assign full     = full_q;
  assign empty    = empty_q;
  assign err      = err_q;
  assign pop_fire = fire && (op == CMD_POP);
  assign bin_fire = fire && is_binary(op);
endmodule

// File: rtl/rpn_stack_engine.sv
`timescale 1ns/1ps
module rpn_stack_engine
  import rpn_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PTR_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] top_data,
  output logic              full,
  output logic              empty,
  output logic              err
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  // Reset: asserted asynchronously, released through a flop chain.
  logic [SYNC_STAGES-1:0] rst_chain_q;
  logic                   srst_n;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_chain_q[g] <= 1'b0;
        end else begin
          if (g == 0) rst_chain_q[g] <= 1'b1;
          else        rst_chain_q[g] <= rst_chain_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate
  assign srst_n = rst_chain_q[SYNC_STAGES-1];

  cmd_e              op;
  logic [PTR_W-1:0]  sp;
  logic              wr_en, pop_fire, bin_fire;
  logic [PTR_W-1:0]  wr_addr;
  logic [DATA_W-1:0] wr_data, rd_top, rd_nxt, alu_res;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  assign op = cmd_e'(cmd_op);

  rpn_ptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (srst_n),
    .cmd_valid(cmd_valid),
    .op       (op),
    .sp       (sp),
    .full     (full),
    .empty    (empty),
    .err      (err),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .pop_fire (pop_fire),
    .bin_fire (bin_fire)
  );

  rpn_stack_mem #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
    .clk        (clk),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_top_addr(sp),
    .rd_nxt_addr(sp - ONE),
    .rd_top_data(rd_top),
    .rd_nxt_data(rd_nxt)
  );

  rpn_alu #(.DATA_W(DATA_W)) u_alu (
    .op (op),
    .lhs(rd_nxt),
    .rhs(rd_top),
    .res(alu_res)
  );

  assign wr_data = bin_fire ? alu_res : cmd_data;

  always_comb begin
    rsp_valid_d = pop_fire;
    rsp_data_d  = pop_fire ? rd_top : rsp_data_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (pop_fire) rsp_data_q <= rsp_data_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign top_data  = empty ? '0 : rd_top;
endmodule

// File: rtl/rpn_stack_checker.sv
`timescale 1ns/1ps
module rpn_stack_checker #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [PTR_W-1:0]  sp,
  input logic              full,
  input logic              empty,
  input logic              err,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic [DATA_W-1:0] top_data
);
  AST_EMPTY_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (sp == '0));                                                   // R1
  AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0 && !full) |=> !empty);                      // R2
  AST_POP_RETURNS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && !empty) |=>
      (rsp_valid && rsp_data == $past(top_data)));                           // R3
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));                                                       // R6
  AST_FULL_PUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0 && full) |=>
      ($stable(sp) && full && err && $stable(top_data)));                    // R7
  AST_EMPTY_POP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && empty) |=> (!rsp_valid && empty && err)); // R8
  AST_RSVD_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7) |=> ($stable(sp) && err));                 // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);                                                            // R11
endmodule

bind rpn_stack_engine rpn_stack_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .sp       (sp),
  .full     (full),
  .empty    (empty),
  .err      (err),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data),
  .top_data (top_data)
);

// File: tb/tb_rpn_stack_engine.sv
`timescale 1ns/1ps
module tb_rpn_stack_engine;
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_ADD = 3'd2,
                         OP_SUB = 3'd3, OP_MUL = 3'd4, OP_AND = 3'd5,
                         OP_OR = 3'd6, OP_RSVD = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [15:0] cmd_data = 16'd0;
  logic        rsp_valid, full, empty, err;
  logic [15:0] rsp_data, top_data;

  int n_checks = 0;
  int n_errors = 0;
  bit summary_done = 0;

  always #5 clk = ~clk;

  rpn_stack_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .top_data(top_data), .full(full), .empty(empty), .err(err)
  );

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Drive one command for one cycle; return at the negedge after the
  // capturing edge, where registered outputs already reflect it.
  task automatic cmd(logic [2:0] op, logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [15:0] pat(int i);
    return 16'((i * 257 + 3) & 16'hFFFF);
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 err", 32'(err), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 top", 32'(top_data), 0);
  endtask

  task automatic t_push_pop();
    do_reset();
    cmd(OP_PUSH, 16'hA5A5);
    check("R2 top", 32'(top_data), 32'hA5A5);
    check("R2 empty cleared", 32'(empty), 0);
    cmd(OP_PUSH, 16'h1234);
    check("R2 top second", 32'(top_data), 32'h1234);
    cmd(OP_POP, 16'h0);
    check("R3 rsp_valid", 32'(rsp_valid), 1);
    check("R3 lifo first", 32'(rsp_data), 32'h1234);
    check("R3 not empty", 32'(empty), 0);
    @(negedge clk);
    check("R3 pulse one cycle", 32'(rsp_valid), 0);
    cmd(OP_POP, 16'h0);
    check("R3 lifo second", 32'(rsp_data), 32'hA5A5);
    check("R3 empty at zero", 32'(empty), 1);
    check("R3 err clear", 32'(err), 0);
  endtask

  task automatic t_binop(logic [2:0] op, logic [15:0] a, logic [15:0] b,
                         logic [15:0] exp, string tag);
    do_reset();
    cmd(OP_PUSH, a);
    cmd(OP_PUSH, b);
    cmd(op, 16'h0);
    check({"R4 ", tag, " top"}, 32'(top_data), 32'(exp));
    check({"R4 ", tag, " no rsp"}, 32'(rsp_valid), 0);
    cmd(OP_POP, 16'h0);
    check({"R4 ", tag, " pop"}, 32'(rsp_data), 32'(exp));
    check({"R4 ", tag, " one entry left"}, 32'(empty), 1);
  endtask

  task automatic t_rpn();
    do_reset();
    cmd(OP_PUSH, 16'd3); check("R5 top 3", 32'(top_data), 3);
    cmd(OP_PUSH, 16'd4); check("R5 top 4", 32'(top_data), 4);
    cmd(OP_MUL, 16'd0);  check("R5 top 12", 32'(top_data), 12);
    cmd(OP_PUSH, 16'd5); check("R5 top 5", 32'(top_data), 5);
    cmd(OP_PUSH, 16'd6); check("R5 top 6", 32'(top_data), 6);
    cmd(OP_MUL, 16'd0);  check("R5 top 30", 32'(top_data), 30);
    cmd(OP_ADD, 16'd0);  check("R5 top 42", 32'(top_data), 42);
    cmd(OP_POP, 16'd0);
    check("R5 result", 32'(rsp_data), 42);
    check("R5 single entry", 32'(empty), 1);
  endtask

  task automatic t_full();
    int bad;
    do_reset();
    for (int i = 0; i < 63; i++) cmd(OP_PUSH, pat(i));
    check("R6 not full at 63", 32'(full), 0);
    cmd(OP_PUSH, pat(63));
    check("R6 full at 64", 32'(full), 1);
    check("R6 top", 32'(top_data), 32'(pat(63)));
    cmd(OP_PUSH, 16'hDEAD);
    check("R7 top unchanged", 32'(top_data), 32'(pat(63)));
    check("R7 still full", 32'(full), 1);
    check("R7 err", 32'(err), 1);
    cmd(OP_ADD, 16'h0);
    check("R12 wrap sum", 32'(top_data), 32'(16'(pat(62) + pat(63))));
    check("R12 full cleared", 32'(full), 0);
    cmd(OP_POP, 16'h0);
    check("R12 pop sum", 32'(rsp_data), 32'(16'(pat(62) + pat(63))));
    bad = 0;
    for (int i = 61; i >= 0; i--) begin
      cmd(OP_POP, 16'h0);
      if (rsp_data !== pat(i) || rsp_valid !== 1'b1) bad++;
    end
    check("R7 contents intact", 32'(bad), 0);
    check("R7 drained empty", 32'(empty), 1);
  endtask

  task automatic t_empty_pop();
    do_reset();
    cmd(OP_POP, 16'h0);
    check("R8 no rsp", 32'(rsp_valid), 0);
    check("R8 still empty", 32'(empty), 1);
    check("R8 full unchanged", 32'(full), 0);
    check("R8 err", 32'(err), 1);
    cmd(OP_PUSH, 16'h0042);
    check("R11 err sticky after push", 32'(err), 1);
    cmd(OP_POP, 16'h0);
    check("R11 err sticky after pop", 32'(err), 1);
    do_reset();
    check("R11 err cleared by reset", 32'(err), 0);
  endtask

  task automatic t_short_op();
    do_reset();
    cmd(OP_PUSH, 16'h0077);
    cmd(OP_SUB, 16'h0);
    check("R9 top unchanged", 32'(top_data), 32'h77);
    check("R9 err", 32'(err), 1);
    cmd(OP_POP, 16'h0);
    check("R9 entry kept", 32'(rsp_data), 32'h77);
    check("R9 one entry", 32'(empty), 1);
    do_reset();
    cmd(OP_OR, 16'h0);
    check("R9 empty op err", 32'(err), 1);
    check("R9 empty op stays empty", 32'(empty), 1);
  endtask

  task automatic t_rsvd();
    do_reset();
    cmd(OP_PUSH, 16'h0101);
    cmd(OP_PUSH, 16'h0202);
    cmd(OP_RSVD, 16'h0303);
    check("R10 top unchanged", 32'(top_data), 32'h0202);
    check("R10 err", 32'(err), 1);
    check("R10 no rsp", 32'(rsp_valid), 0);
    cmd(OP_POP, 16'h0);
    cmd(OP_POP, 16'h0);
    check("R10 depth unchanged", 32'(rsp_data), 32'h0101);
    check("R10 empty after two", 32'(empty), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_push_pop();
    t_binop(OP_ADD, 16'hFFFF, 16'h0003, 16'h0002, "add wrap");
    t_binop(OP_SUB, 16'd100, 16'd30, 16'd70, "sub order");
    t_binop(OP_SUB, 16'd5, 16'd9, 16'hFFFC, "sub negative");
    t_binop(OP_MUL, 16'h1234, 16'h0100, 16'h3400, "mul low half");
    t_binop(OP_AND, 16'hF0F0, 16'h3C3C, 16'h3030, "and");
    t_binop(OP_OR, 16'hF000, 16'h000F, 16'hF00F, "or");
    t_rpn();
    t_full();
    t_empty_pop();
    t_short_op();
    t_rsvd();
    summary();
  end
endmodule